// File: doc/BRIEF.md
# Dual-Direction Word Queue with Threshold Requests

This block holds two independent word queues, one for outgoing words (transmit) and one for incoming words (receive). It sits between a register interface and a serial shift engine. Each queue takes words up to the programmed frame width and reports how many it holds. Each raises a service request when its fill level reaches a programmable threshold. Each also records, in sticky flags, any write that found it full and any read that found it empty.

The two directions share only the clock, the reset and the frame width. Each has its own enable, flush, threshold, error clear, write port and read port. A disabled queue keeps working, but it holds one word, like a plain holding register in front of a shifter. The transmit request asks for more data while the queue is low. The receive request asks for draining while the queue is high.

Top module: `sfq_pair`

## Requirements
- R1: After reset both levels are 0, all error flags are 0 and both read data outputs are 0.
- R2: With its enable high, a queue accepts up to DEPTH (8) words. It returns them in write order, and its level output equals the count it holds.
- R3: A stored word keeps only its low N bits, the rest reading as 0. N is `frame_bits` clamped to the range 2..16, so 0 or 1 act as 2 and anything above 16 acts as 16.
- R4: The receive request is 1 exactly when the receive level is greater than or equal to `rx_trig`.
- R5: The transmit request is 1 exactly when the transmit level is less than or equal to `tx_trig`.
- R6: A write to a full queue with no successful read in the same cycle is discarded and sets the overrun flag. A write and a read together at a full queue both take effect, and the level stays the same.
- R7: A read from an empty queue sets the underflow flag. The read data output keeps the last word read before it, and a write in that same cycle is still stored.
- R8: An error flag stays set until its direction's `err_clr` is 1. When an error event and a clear come in the same cycle, the flag ends up set.
- R9: A flush makes the level 0 on the next cycle. Any write or read in the flush cycle is ignored, and the other direction is not affected.
- R10: With its enable low, a queue holds at most one word. A second write before a read is an overrun.
- R11: A successful read presents its word on the read data output one cycle later, and the output holds it until the next successful read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_bits | input | 5 | Programmed frame width in bits (clamped 2..16) |
| tx_en | input | 1 | Transmit queue enable (0 = single-word mode) |
| tx_flush | input | 1 | Empty the transmit queue |
| tx_err_clr | input | 1 | Clear transmit overrun and underflow flags |
| tx_trig | input | 4 | Transmit request threshold |
| tx_wr | input | 1 | Transmit write strobe |
| tx_wdata | input | 16 | Transmit write word |
| tx_rd | input | 1 | Transmit read strobe (shift engine side) |
| tx_rdata | output | 16 | Transmit read word |
| tx_level | output | 4 | Transmit fill level |
| tx_req | output | 1 | Transmit service request |
| tx_ovr | output | 1 | Transmit overrun flag |
| tx_udf | output | 1 | Transmit underflow flag |
| rx_en | input | 1 | Receive queue enable (0 = single-word mode) |
| rx_flush | input | 1 | Empty the receive queue |
| rx_err_clr | input | 1 | Clear receive overrun and underflow flags |
| rx_trig | input | 4 | Receive request threshold |
| rx_wr | input | 1 | Receive write strobe (shift engine side) |
| rx_wdata | input | 16 | Receive write word |
| rx_rd | input | 1 | Receive read strobe |
| rx_rdata | output | 16 | Receive read word |
| rx_level | output | 4 | Receive fill level |
| rx_req | output | 1 | Receive service request |
| rx_ovr | output | 1 | Receive overrun flag |
| rx_udf | output | 1 | Receive underflow flag |

## Verification
The bench builds the block with its defaults, WIDTH 16 and DEPTH 8, so the level runs through all nine values 0..8. That makes a ninth write, a combined write and read at the full mark, and thresholds at both ends of the range easy to reach. The 5-bit frame width input can carry values below 2 and above 16, so both clamp directions are driven. Single-word mode is reached by dropping an enable while that queue is empty.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

  // Effective frame width: clamp the programmed value into 2..w
  function automatic int eff_bits(input int fb, input int w);
    if (fb < 2) return 2;
    if (fb > w) return w;
    return fb;
  endfunction

  // Receive side wants service when filled to the threshold or beyond
  function automatic logic rx_want(input int lvl, input int trig);
    return lvl >= trig;
  endfunction

  // Transmit side wants service when drained to the threshold or below
  function automatic logic tx_want(input int lvl, input int trig);
    return lvl <= trig;
  endfunction

  // Ring pointer advance for any depth
  function automatic int ptr_next(input int p, input int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/sfq_mem.sv
module sfq_mem #(
  parameter int W  = 16,
  parameter int D  = 8,
  parameter int AW = (D > 1) ? $clog2(D) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [D];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  // Registered read port; holds its value when no read happens
  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/sfq_sticky.sv
module sfq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr) |=> q)
    else $error("sticky flag dropped without clear");

  // R8
  set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q)
    else $error("sticky flag missed a set");
endmodule

// File: rtl/sfq_lane.sv
module sfq_lane
  import sfq_pkg::*;
#(
  parameter int W     = 16,
  parameter int D     = 8,
  parameter bit IS_RX = 1'b0,
  parameter int LW    = $clog2(D + 1),
  parameter int FBW   = $clog2(W + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [FBW-1:0] frame_bits,
  input  logic           en,
  input  logic           flush,
  input  logic           err_clr,
  input  logic [LW-1:0]  trig,
  input  logic           wr,
  input  logic [W-1:0]   wdata,
  input  logic           rd,
  output logic [W-1:0]   rdata,
  output logic [LW-1:0]  level,
  output logic           req,
  output logic           ovr,
  output logic           udf
);
  localparam int AW = (D > 1) ? $clog2(D) : 1;

  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] cap;
  logic          full, empty;
  logic          rd_ok, wr_ok, ovr_evt, udf_evt;
  logic [W-1:0]  wmask, wstore;

  assign cap   = en ? LW'(D) : LW'(1);
  assign full  = level >= cap;
  assign empty = level == '0;

  // Named internal events
  assign rd_ok   = rd && !empty && !flush;
  assign udf_evt = rd && empty && !flush;
  assign ovr_evt = wr && full && !rd_ok && !flush;
  assign wr_ok   = wr && !flush && !ovr_evt;

  always_comb begin
    int nb;
    nb = eff_bits(int'(frame_bits), W);
    for (int i = 0; i < W; i++) wmask[i] = (i < nb);
  end
  assign wstore = wdata & wmask;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr_ok) wptr <= AW'(ptr_next(int'(wptr), D));
      if (rd_ok) rptr <= AW'(ptr_next(int'(rptr), D));
      level <= level + LW'(wr_ok) - LW'(rd_ok);
    end
  end

  sfq_mem #(.W(W), .D(D), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .we(wr_ok), .waddr(wptr), .wdata(wstore),
    .re(rd_ok), .raddr(rptr), .rdata(rdata)
  );

  sfq_sticky u_ovr (.clk(clk), .rst_n(rst_n), .set(ovr_evt), .clr(err_clr), .q(ovr));
  sfq_sticky u_udf (.clk(clk), .rst_n(rst_n), .set(udf_evt), .clr(err_clr), .q(udf));

  generate
    if (IS_RX) begin : g_rx_req
      assign req = rx_want(int'(level), int'(trig));
    end else begin : g_tx_req
      assign req = tx_want(int'(level), int'(trig));
    end
  endgenerate

  // R2
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(D))
    else $error("level above depth");

  // R6
  ovr_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> level == $past(level))
    else $error("overrun changed level");

  // R7
  udf_holds_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    udf_evt |=> $stable(rdata))
    else $error("underflow changed read data");

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> level == '0)
    else $error("flush left words behind");

  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |=> $stable(rdata))
    else $error("read data moved without a read");
endmodule

// File: rtl/sfq_pair.sv
module sfq_pair #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1),
  parameter int FB_W  = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FB_W-1:0]  frame_bits,
  input  logic             tx_en,
  input  logic             tx_flush,
  input  logic             tx_err_clr,
  input  logic [LVL_W-1:0] tx_trig,
  input  logic             tx_wr,
  input  logic [WIDTH-1:0] tx_wdata,
  input  logic             tx_rd,
  output logic [WIDTH-1:0] tx_rdata,
  output logic [LVL_W-1:0] tx_level,
  output logic             tx_req,
  output logic             tx_ovr,
  output logic             tx_udf,
  input  logic             rx_en,
  input  logic             rx_flush,
  input  logic             rx_err_clr,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             rx_wr,
  input  logic [WIDTH-1:0] rx_wdata,
  input  logic             rx_rd,
  output logic [WIDTH-1:0] rx_rdata,
  output logic [LVL_W-1:0] rx_level,
  output logic             rx_req,
  output logic             rx_ovr,
  output logic             rx_udf
);
  sfq_lane #(.W(WIDTH), .D(DEPTH), .IS_RX(1'b0), .LW(LVL_W), .FBW(FB_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .frame_bits(frame_bits),
    .en(tx_en), .flush(tx_flush), .err_clr(tx_err_clr), .trig(tx_trig),
    .wr(tx_wr), .wdata(tx_wdata), .rd(tx_rd), .rdata(tx_rdata),
    .level(tx_level), .req(tx_req), .ovr(tx_ovr), .udf(tx_udf)
  );

  sfq_lane #(.W(WIDTH), .D(DEPTH), .IS_RX(1'b1), .LW(LVL_W), .FBW(FB_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .frame_bits(frame_bits),
    .en(rx_en), .flush(rx_flush), .err_clr(rx_err_clr), .trig(rx_trig),
    .wr(rx_wr), .wdata(rx_wdata), .rd(rx_rd), .rdata(rx_rdata),
    .level(rx_level), .req(rx_req), .ovr(rx_ovr), .udf(rx_udf)
  );
endmodule

// File: tb/sfq_pair_tb.sv
module sfq_pair_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic        rst_n;
  logic [4:0]  fb;
  logic        en[2], fl[2], clr[2], wr[2], rd[2];
  logic [3:0]  trig[2];
  logic [15:0] wd[2];
  logic [15:0] tx_rdata, rx_rdata;
  logic [3:0]  tx_level, rx_level;
  logic        tx_req, rx_req, tx_ovr, rx_ovr, tx_udf, rx_udf;

  sfq_pair u_dut (
    .clk(clk), .rst_n(rst_n), .frame_bits(fb),
    .tx_en(en[0]), .tx_flush(fl[0]), .tx_err_clr(clr[0]), .tx_trig(trig[0]),
    .tx_wr(wr[0]), .tx_wdata(wd[0]), .tx_rd(rd[0]), .tx_rdata(tx_rdata),
    .tx_level(tx_level), .tx_req(tx_req), .tx_ovr(tx_ovr), .tx_udf(tx_udf),
    .rx_en(en[1]), .rx_flush(fl[1]), .rx_err_clr(clr[1]), .rx_trig(trig[1]),
    .rx_wr(wr[1]), .rx_wdata(wd[1]), .rx_rd(rd[1]), .rx_rdata(rx_rdata),
    .rx_level(rx_level), .rx_req(rx_req), .rx_ovr(rx_ovr), .rx_udf(rx_udf)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // Reference model state
  logic [15:0] mq[2][8];
  int          mc[2];
  logic        mo[2], mu[2];
  logic [15:0] ml[2];
  logic [15:0] exp_tx[$], exp_rx[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mask_of(input logic [4:0] f);
    int nb;
    nb = (f < 2) ? 2 : ((f > 16) ? 16 : int'(f));
    return 16'((32'h1 << nb) - 1);
  endfunction

  // Driver: compute the model step, clock once, hand expected reads to the monitor
  task automatic tick();
    bit          push[2];
    logic [15:0] pw[2];
    for (int d = 0; d < 2; d++) begin
      int  cap;
      bit  full, empty, rok, oe, ue;
      push[d] = 0; pw[d] = '0;
      cap = en[d] ? 8 : 1;
      full = mc[d] >= cap; empty = mc[d] == 0;
      if (fl[d]) begin
        mc[d] = 0; oe = 0; ue = 0;
      end else begin
        rok = rd[d] && !empty;
        ue  = rd[d] && empty;
        oe  = wr[d] && full && !rok;
        if (rok) begin
          ml[d] = mq[d][0];
          for (int i = 0; i < 7; i++) mq[d][i] = mq[d][i+1];
          mc[d]--;
        end
        if (rok || ue) begin push[d] = 1; pw[d] = ml[d]; end
        if (wr[d] && !oe) begin mq[d][mc[d]] = wd[d] & mask_of(fb); mc[d]++; end
      end
      mo[d] = oe ? 1'b1 : (clr[d] ? 1'b0 : mo[d]);
      mu[d] = ue ? 1'b1 : (clr[d] ? 1'b0 : mu[d]);
    end
    @(posedge clk); #1;
    if (push[0]) exp_tx.push_back(pw[0]);
    if (push[1]) exp_rx.push_back(pw[1]);
    for (int d = 0; d < 2; d++) begin wr[d] = 0; rd[d] = 0; fl[d] = 0; clr[d] = 0; end
    chk(tx_level == 4'(mc[0]), "R2/R9/R10 tx level", tx_level, mc[0]);
    chk(rx_level == 4'(mc[1]), "R2/R9/R10 rx level", rx_level, mc[1]);
    chk(tx_req == (mc[0] <= int'(trig[0])), "R5 tx req", tx_req, mc[0] <= int'(trig[0]));
    chk(rx_req == (mc[1] >= int'(trig[1])), "R4 rx req", rx_req, mc[1] >= int'(trig[1]));
    chk(tx_ovr == mo[0], "R6/R8 tx ovr", tx_ovr, mo[0]);
    chk(rx_ovr == mo[1], "R6/R8 rx ovr", rx_ovr, mo[1]);
    chk(tx_udf == mu[0], "R7/R8 tx udf", tx_udf, mu[0]);
    chk(rx_udf == mu[1], "R7/R8 rx udf", rx_udf, mu[1]);
  endtask

  // Monitor: compare each read result one cycle after the read (R11)
  always @(negedge clk) begin
    if (exp_tx.size() > 0) begin
      logic [15:0] e;
      e = exp_tx.pop_front();
      chk(tx_rdata == e, "R3/R11 tx rdata", tx_rdata, e);
    end
    if (exp_rx.size() > 0) begin
      logic [15:0] e;
      e = exp_rx.pop_front();
      chk(rx_rdata == e, "R3/R11 rx rdata", rx_rdata, e);
    end
  end

  initial begin
    #(4 * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 0; fb = 5'd16;
    for (int d = 0; d < 2; d++) begin
      en[d] = 1; fl[d] = 0; clr[d] = 0; wr[d] = 0; rd[d] = 0; wd[d] = '0; trig[d] = 4'd2;
      mc[d] = 0; mo[d] = 0; mu[d] = 0; ml[d] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk(tx_level == 0 && rx_level == 0, "R1 levels", {tx_level, rx_level}, 0);
    chk({tx_ovr, tx_udf, rx_ovr, rx_udf} == 4'b0, "R1 flags", {tx_ovr, tx_udf, rx_ovr, rx_udf}, 0);
    chk(tx_rdata == 0 && rx_rdata == 0, "R1 rdata", tx_rdata | rx_rdata, 0);

    // R2 / R6: fill transmit queue, ninth write overruns
    trig[0] = 4'd3;
    for (int i = 0; i < 9; i++) begin wr[0] = 1; wd[0] = 16'hA000 + 16'(i * 37); tick(); end
    tick();   // R8 flag held with no clear
    // R2 / R7: drain, ninth read underflows and keeps last word
    for (int i = 0; i < 9; i++) begin rd[0] = 1; tick(); end
    clr[0] = 1; tick();

    // R3 masking with clamps
    fb = 5'd5;  wr[1] = 1; wd[1] = 16'hFFFF; tick();
    fb = 5'd0;  wr[1] = 1; wd[1] = 16'hFFFF; tick();
    fb = 5'd20; wr[1] = 1; wd[1] = 16'h8001; tick();
    fb = 5'd16;
    for (int i = 0; i < 3; i++) begin rd[1] = 1; tick(); end

    // R4 / R5 threshold sweep at level 4 on both sides
    for (int i = 0; i < 4; i++) begin
      wr[0] = 1; wd[0] = 16'h1100 + 16'(i); wr[1] = 1; wd[1] = 16'h2200 + 16'(i); tick();
    end
    for (int t = 0; t <= 8; t++) begin trig[0] = 4'(t); trig[1] = 4'(t); tick(); end
    trig[1] = 4'd8;
    // fill receive to 8, then write + read at full (R6)
    for (int i = 0; i < 4; i++) begin wr[1] = 1; wd[1] = 16'h3300 + 16'(i); tick(); end
    wr[1] = 1; wd[1] = 16'h4444; rd[1] = 1; tick();
    // R9: flush transmit with a write and read in the same cycle; receive untouched
    fl[0] = 1; wr[0] = 1; wd[0] = 16'h5555; rd[0] = 1; tick();
    tick();
    fl[1] = 1; tick();
    // R8: underflow event and clear in the same cycle; R7 write alongside underflow
    rd[1] = 1; clr[1] = 1; wr[1] = 1; wd[1] = 16'h6666; tick();
    clr[1] = 1; tick();
    rd[1] = 1; tick();
    // R10 single-word mode
    en[0] = 0;
    wr[0] = 1; wd[0] = 16'h7001; tick();
    wr[0] = 1; wd[0] = 16'h7002; tick();
    rd[0] = 1; tick();
    rd[0] = 1; tick();
    clr[0] = 1; tick();
    en[0] = 1;
    // Mixed traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wr[0] = lfsr[0]; rd[0] = lfsr[3] & lfsr[1]; wd[0] = lfsr;
      wr[1] = lfsr[5]; rd[1] = lfsr[2]; wd[1] = ~lfsr;
      clr[0] = (lfsr[9:7] == 3'b111); clr[1] = (lfsr[11:9] == 3'b000);
      fb = 5'(lfsr[14:10]);
      trig[0] = 4'(lfsr[7:4] % 9); trig[1] = 4'(lfsr[11:8] % 9);
      tick();
    end
    @(posedge clk); #1;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule